// File: doc/BRIEF.md
# Nibble-Wide DRAM Access Sequencer

This block runs the memory access sequence for one 2 MHz period in eight equal steps. A single 8-bit one-hot phase ring picks the step. In each period the block fetches one byte from a DRAM that is four bits wide and uses a multiplexed row/column address. The byte arrives as two half-byte column accesses under one row strobe. A byte at address `a` is stored as two nibbles. The high nibble sits at nibble address `2a` and the low nibble at `2a+1`. Both nibbles share a row, so the two column addresses differ only in their least significant bit.

An access divider counts periods modulo a programmable value. In a period where the divider stands at zero, the display address is used and the assembled byte is reported with a display-ready pulse. In any other period the CPU address is passed to the DRAM. If the CPU asked for a read in that period, the byte is assembled the same way and reported with a CPU-ready pulse.

Top module: `nib_dram_seq`

## Requirements
- R1: After reset `phase` is 8'h01. Each clock it rotates left by one bit, so 8'h80 is followed by 8'h01, and exactly one bit is set at all times.
- R2: `row_sel` is high exactly in the phases 8'h02, 8'h04, 8'h08, 8'h10, 8'h20 and 8'h40.
- R3: `col_sel` is high exactly in the phases 8'h04, 8'h08, 8'h20 and 8'h40, and never without `row_sel`.
- R4: In phase 8'h01, `mem_addr` carries the row, which is bits [14:7] of the byte address. In phases 8'h02, 8'h04 and 8'h08 it carries the even column `{addr[6:0],1'b0}`. In phases 8'h10 to 8'h80 it carries the odd column `{addr[6:0],1'b1}`.
- R5: The address used in a period is taken in phase 8'h01: `vid_addr` in a display period, `cpu_addr` otherwise. It is held for the rest of the period, whatever the address inputs do.
- R6: The access divider starts at 0 and advances once per period, at the end of phase 8'h80, modulo `acc_period`. A period is a display period when the divider is 0. An `acc_period` of 0 or 1 makes every period a display period.
- R7: In a period that fetches, `dram_q` is sampled in phase 8'h08 as the high nibble and in phase 8'h40 as the low nibble. `rd_byte` shows `{high,low}`.
- R8: `vid_ready` is high for exactly the phase-8'h01 cycle that follows a display period. `cpu_ready` is high for exactly the phase-8'h01 cycle that follows a CPU period in which `cpu_rd` was high at phase 8'h01. The two are never high together.
- R9: A CPU period with `cpu_rd` low at phase 8'h01 leaves `rd_byte` unchanged and raises neither ready pulse.
- R10: While `rst` is high at a clock edge, the phase ring goes to 8'h01 and the divider to 0. Both strobes and both ready pulses are low, and `rd_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, eight ticks per access period |
| rst | input | 1 | Synchronous reset, active high |
| acc_period | input | 4 | Divider modulus: one display fetch every `acc_period` periods |
| vid_addr | input | 15 | Byte address requested by the display |
| cpu_addr | input | 15 | Byte address from the CPU |
| cpu_rd | input | 1 | CPU read request, sampled in phase 8'h01 |
| dram_q | input | 4 | DRAM read data nibble |
| phase | output | 8 | One-hot phase ring state |
| mem_addr | output | 8 | Multiplexed row/column address to the DRAM |
| row_sel | output | 1 | Row strobe, active high |
| col_sel | output | 1 | Column strobe, active high |
| rd_byte | output | 8 | Assembled byte, high nibble first |
| vid_ready | output | 1 | One-cycle pulse: display byte complete |
| cpu_ready | output | 1 | One-cycle pulse: CPU read byte complete |

## Verification
A corrupted phase ring shows at once. The strobes and the address multiplexer decode `phase` directly, so a lost or doubled bit breaks `row_sel`, `col_sel` or `mem_addr` in the same cycle. A wrong divider value changes the source address at the next phase 8'h01, and the ready pulse named for that period arrives eight cycles later. A nibble captured in the wrong phase, or a byte captured when it should not be, shows in `rd_byte` on the cycle after the capture edge. The bench compares every output on every clock against a behavioural model, so each of these faults is caught within one period.

// File: rtl/nds_pkg.sv
package nds_pkg;
  localparam int PH_N = 8;
  typedef logic [PH_N-1:0] phase_t;

  localparam phase_t PH_ROW  = 8'h01;
  localparam phase_t PH_LAST = 8'h80;

  function automatic phase_t rotl1(input phase_t v);
    return {v[PH_N-2:0], v[PH_N-1]};
  endfunction

  // strobe decodes, one place so both the top and any checker agree
  function automatic logic row_active(input phase_t v);
    return |v[6:1];
  endfunction

  function automatic logic col_active(input phase_t v);
    return v[2] | v[3] | v[5] | v[6];
  endfunction

  function automatic logic second_half(input phase_t v);
    return |v[7:4];
  endfunction
endpackage

// File: rtl/nds_phase_ring.sv
module nds_phase_ring
  import nds_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t ph
);
  always_ff @(posedge clk) begin
    if (rst) ph <= PH_ROW;
    else     ph <= rotl1(ph);
  end

  AST_PH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(ph) == 1); // R1
  AST_PH_WRAP: assert property (@(posedge clk) disable iff (rst)
    ph[7] |=> ph[0]); // R1
endmodule

// File: rtl/nds_access_div.sv
module nds_access_div #(
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [ACC_W-1:0] period,
  output logic             due
);
  logic [ACC_W-1:0] cnt;

  function automatic logic [ACC_W-1:0] next_cnt(input logic [ACC_W-1:0] c,
                                                input logic [ACC_W-1:0] p);
    logic [ACC_W:0] inc;
    inc = {1'b0, c} + 1'b1;
    return (inc >= {1'b0, p}) ? '0 : inc[ACC_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= next_cnt(cnt, period);
  end

  assign due = (cnt == '0);

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R6
endmodule

// File: rtl/nds_nibble_cap.sv
module nds_nibble_cap #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_hi,
  input  logic               cap_lo,
  input  logic [NIB_W-1:0]   din,
  output logic [2*NIB_W-1:0] byte_q
);
  logic [NIB_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (cap_hi) hi_q <= din;
      if (cap_lo) lo_q <= din;
    end
  end

  assign byte_q = {hi_q, lo_q};

  AST_CAP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cap_hi && cap_lo)); // R7
endmodule

// File: rtl/nib_dram_seq.sv
module nib_dram_seq
  import nds_pkg::*;
#(
  parameter int MUX_W = 8,
  parameter int NIB_W = 4,
  parameter int ACC_W = 4,
  localparam int BYTE_W = 2 * MUX_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ACC_W-1:0]   acc_period,
  input  logic [BYTE_W-1:0]  vid_addr,
  input  logic [BYTE_W-1:0]  cpu_addr,
  input  logic               cpu_rd,
  input  logic [NIB_W-1:0]   dram_q,
  output logic [7:0]         phase,
  output logic [MUX_W-1:0]   mem_addr,
  output logic               row_sel,
  output logic               col_sel,
  output logic [2*NIB_W-1:0] rd_byte,
  output logic               vid_ready,
  output logic               cpu_ready
);
  phase_t            ph;
  logic              due;
  logic              use_vid_q, rd_q;
  logic [BYTE_W-1:0] addr_q, live_addr;
  logic              need_data, cap_hi, cap_lo;

  nds_phase_ring i_ring (.clk(clk), .rst(rst), .ph(ph));

  nds_access_div #(.ACC_W(ACC_W)) i_div (
    .clk(clk), .rst(rst), .step(ph[7]), .period(acc_period), .due(due)
  );

  assign live_addr = due ? vid_addr : cpu_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      use_vid_q <= 1'b0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      vid_ready <= 1'b0;
      cpu_ready <= 1'b0;
    end else begin
      if (ph[0]) begin
        use_vid_q <= due;
        rd_q      <= cpu_rd;
        addr_q    <= live_addr;
      end
      vid_ready <= ph[7] & use_vid_q;
      cpu_ready <= ph[7] & ~use_vid_q & rd_q;
    end
  end

  assign need_data = use_vid_q | rd_q;
  assign cap_hi    = ph[3] & need_data;
  assign cap_lo    = ph[6] & need_data;

  nds_nibble_cap #(.NIB_W(NIB_W)) i_cap (
    .clk(clk), .rst(rst), .cap_hi(cap_hi), .cap_lo(cap_lo),
    .din(dram_q), .byte_q(rd_byte)
  );

  assign phase    = ph;
  assign row_sel  = row_active(ph);
  assign col_sel  = col_active(ph);
  assign mem_addr = ph[0] ? live_addr[BYTE_W-1:MUX_W-1]
                          : {addr_q[MUX_W-2:0], second_half(ph)};

  AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (rst)
    col_sel |-> row_sel); // R3
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(vid_ready && cpu_ready)); // R8
  AST_READY_SLOT: assert property (@(posedge clk) disable iff (rst)
    (vid_ready || cpu_ready) |-> phase[0]); // R8
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase[2] || phase[3] || phase[5] || phase[6] || phase[7]) |-> $stable(mem_addr)); // R4
  AST_IDLE_BYTE: assert property (@(posedge clk) disable iff (rst)
    (phase[1] && !need_data) |=> $stable(rd_byte)); // R9
endmodule

// File: tb/test_nib_dram_seq.sv
module test_nib_dram_seq;
  localparam int MW = 8;
  localparam int BW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    acc_period = 4'd1;
  logic [BW-1:0] vid_addr = '0;
  logic [BW-1:0] cpu_addr = '0;
  logic          cpu_rd = 1'b0;
  logic [3:0]    dram_q = '0;
  logic [7:0]    phase;
  logic [MW-1:0] mem_addr;
  logic          row_sel, col_sel, vid_ready, cpu_ready;
  logic [7:0]    rd_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nib_dram_seq i_nib_dram_seq (
    .clk(clk), .rst(rst), .acc_period(acc_period), .vid_addr(vid_addr),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .dram_q(dram_q), .phase(phase),
    .mem_addr(mem_addr), .row_sel(row_sel), .col_sel(col_sel),
    .rd_byte(rd_byte), .vid_ready(vid_ready), .cpu_ready(cpu_ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // model state
  int t, per, mdl_addr, hi, lo;
  bit cur_disp, cur_rd, prv_disp, prv_rd;

  task automatic do_reset(input int p);
    rst = 1'b1;
    acc_period = p[3:0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10", "phase", phase, 8'h01);
    chk("R10", "row_sel", row_sel, 0);
    chk("R10", "col_sel", col_sel, 0);
    chk("R10", "vid_ready", vid_ready, 0);
    chk("R10", "cpu_ready", cpu_ready, 0);
    chk("R10", "rd_byte", rd_byte, 0);
    rst = 1'b0;
    per = p; t = 0; hi = 0; lo = 0;
    cur_disp = 0; cur_rd = 0; prv_disp = 0; prv_rd = 0; mdl_addr = 0;
  endtask

  // one cycle: drive inputs, compare, update model
  task automatic step(input int rd_mode);
    int k, n, src, exp_addr, ph_exp;
    bit exp_row, exp_col;
    if (t != 0) @(negedge clk);
    vid_addr = BW'($urandom);
    cpu_addr = BW'($urandom);
    dram_q   = 4'($urandom);
    cpu_rd   = (rd_mode == 2) ? 1'($urandom) : rd_mode[0];
    #1;
    k = t % 8; n = t / 8;
    ph_exp = 1 << k;
    if (k == 0) begin
      prv_disp = cur_disp; prv_rd = cur_rd;
      cur_disp = (per <= 1) || (n % per == 0);
      cur_rd = cpu_rd;
      src = cur_disp ? int'(vid_addr) : int'(cpu_addr);
      mdl_addr = src;
      exp_addr = src >> (MW - 1);
    end else begin
      exp_addr = ((mdl_addr & ((1 << (MW-1)) - 1)) << 1) | ((k >= 4) ? 1 : 0);
    end
    exp_row = (k >= 1 && k <= 6);
    exp_col = (k == 2 || k == 3 || k == 5 || k == 6);
    chk("R1", "phase", phase, ph_exp);
    chk("R2", "row_sel", row_sel, exp_row);
    chk("R3", "col_sel", col_sel, exp_col);
    if (k == 0) chk(cur_disp ? "R5 R6 disp" : "R5 R6 cpu", "mem_addr row", mem_addr, exp_addr);
    else        chk("R4", "mem_addr col", mem_addr, exp_addr);
    chk("R8", "vid_ready", vid_ready, (k == 0 && n >= 1 && prv_disp) ? 1 : 0);
    chk((k == 0 && n >= 1 && !prv_disp && !prv_rd) ? "R9" : "R8", "cpu_ready",
        cpu_ready, (k == 0 && n >= 1 && !prv_disp && prv_rd) ? 1 : 0);
    chk((cur_disp || cur_rd) ? "R7" : "R9", "rd_byte", rd_byte, (hi << 4) | lo);
    if (cur_disp || cur_rd) begin
      if (k == 3) hi = dram_q;
      if (k == 6) lo = dram_q;
    end
    t++;
  endtask

  initial begin
    do_reset(3);
    for (int i = 0; i < 240; i++) step(2);
    do_reset(1);
    for (int i = 0; i < 80; i++) step(0);
    do_reset(0);
    for (int i = 0; i < 80; i++) step(1);
    do_reset(5);
    for (int i = 0; i < 200; i++) step(0);
    do_reset(4);
    for (int i = 0; i < 200; i++) step(1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule